// File: doc/BRIEF.md
# SPI Byte Master Serial Engine

This block is the serial core of a full-duplex SPI master that works in bytes. Transmit bytes arrive on a valid/ready stream. Each accepted byte is shifted out on `mosi`, most significant bit first. At the same time eight bits are captured from `miso`, and the result is pushed out on a receive stream that has a valid strobe. The receive side never applies backpressure. If the consumer is not ready when a byte is pushed, the byte is still presented and a loss pulse is raised alongside it.

The block is programmed through three inputs:
- a configuration word, which sets the master bit, clock polarity, clock phase, a power-of-two clock divider, a four-bit active-low chip-select field and a manual chip-select bit;
- an enable input;
- a delay word, which holds three 8-bit delays counted in serial-clock periods.

The serial clock half-period is a power of two of the system clock, so the serial clock period is `2 << div`.

The control is a single state machine with five states:
- `ST_IDLE` waits for a byte.
- `ST_LEAD` is the delay from chip select to the first clock edge.
- `ST_SHIFT` runs the sixteen clock edges of a byte.
- `ST_TRAIL` is the delay after the last edge.
- `ST_GAP` is the idle time before the next byte.

The transitions are:
- IDLE→LEAD on an accepted byte, or IDLE→SHIFT if the lead delay is zero.
- LEAD→SHIFT when the lead count expires.
- SHIFT→TRAIL, SHIFT→GAP or SHIFT→IDLE after the last edge, skipping each delay whose value is zero.
- TRAIL→GAP, or TRAIL→IDLE if the gap is zero.
- GAP→IDLE.
- Any state→IDLE whenever the engine becomes inactive.

Top module: `spi_byte_master`

## Requirements
- R1: The divider field is `cfg_word[5:3]`. The `sclk` half-period is 2^div system cycles, and a field value of 0 is treated as 1. During a byte, `sclk` changes only on these half-period ticks.
- R2: `cfg_word[1]` is CPOL and sets the idle level of `sclk`. `cfg_word[2]` is CPHA. With CPHA=0, `mosi` is valid at the first edge of each bit and is sampled there. With CPHA=1, `mosi` is sampled on the second edge of each bit. Bits go out MSB first, and in all four modes the byte seen on `mosi` at the sampling edges equals the transmitted byte.
- R3: Each accepted byte produces exactly 16 `sclk` edges and exactly one single-cycle `rx_valid` pulse. `rx_data` holds the eight `miso` bits taken at the sampling edges, MSB first.
- R4: The engine is active only when `en`=1 and `cfg_word[0]` (master) = 1. When it is inactive, `tx_ready`=0, no byte is accepted, `cs_n`=4'b1111 and `sclk` rests at CPOL.
- R5: `cfg_word[13:10]` is the active-low chip-select field, one bit per target. In automatic mode `cs_n` equals that field only from byte acceptance until the after-delay ends, and is 4'b1111 otherwise.
- R6: When `cfg_word[14]`=1 (manual select) and the engine is active, `cs_n` equals the field at all times, including while idle and between bytes.
- R7: The lead delay is `dly_word[7:0]`=I. The time from the fall of `cs_n` to the first `sclk` edge is (2·I+1) half-periods.
- R8: The after delay is `dly_word[15:8]`=A. In automatic mode, the time from the last `sclk` edge to the rise of `cs_n` is 2·A half-periods.
- R9: The gap delay is `dly_word[23:16]`=B. In automatic mode, with the next byte already waiting, `cs_n` stays high for 2·B half-periods plus one cycle.
- R10: A received byte is pushed even when `rx_ready`=0. In that case `rx_lost` pulses in the same cycle as `rx_valid`, and `rx_data` is still correct.
- R11: In manual mode with a target selected, reaching `ST_IDLE` at the end of a byte while `tx_valid`=0 gives exactly one single-cycle `tx_underflow` pulse. Automatic mode never raises it.
- R12: Clearing `en` in the middle of a byte aborts it. There is no `rx_valid`, `cs_n` returns to 4'b1111 and `sclk` returns to CPOL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (reference) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| cfg_word | input | 15 | Configuration: master, CPOL, CPHA, divider, chip-select field, manual select |
| dly_word | input | 24 | Lead, after and gap delays in serial-clock periods |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine can accept a byte this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Single-cycle strobe for `rx_data` |
| rx_ready | input | 1 | Receive consumer ready (advisory) |
| rx_lost | output | 1 | Received byte pushed while consumer not ready |
| tx_underflow | output | 1 | Manual-select word boundary with no transmit data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The hardest cases to reach from the ports are the timing windows around chip select. These are the lead time, the trailing hold and the gap between two bytes. They only appear when a second byte is already waiting at the moment the engine returns to idle. The stimulus therefore queues two bytes back to back with non-zero delays and measures, cycle by cycle, the intervals between `cs_n` edges and `sclk` edges.

A second hard case is the abort in the middle of a byte. The stimulus starts a slow transfer, drops `en` partway through, and then confirms that nothing is pushed and that the lines return to idle. A loopback from `mosi` to `miso`, optionally inverted, lets one scoreboard check both the transmitted and the received bytes in every clock mode.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } eng_state_t;

    // Configuration word field positions
    localparam int CFG_W       = 15;
    localparam int CFG_MASTER  = 0;
    localparam int CFG_CPOL    = 1;
    localparam int CFG_CPHA    = 2;
    localparam int CFG_DIV_LSB = 3;
    localparam int CFG_CS_LSB  = 10;
    localparam int CFG_MANCS   = 14;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_q;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign lim     = ~({CNT_W{1'b1}} << div_eff);
    assign tick    = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Half-period of at least two cycles: ticks never come back to back
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              shift_en,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int ECW = $clog2(2 * DATA_W);
    localparam logic [ECW-1:0] LAST = ECW'(2 * DATA_W - 1);

    logic              sclk_q;
    logic              mosi_q;
    logic [ECW-1:0]    ecnt_q;
    logic [DATA_W-1:0] txs_q;
    logic [DATA_W-1:0] rxs_q;
    logic              samp_edge;
    logic              drive_edge;

    assign samp_edge  = (ecnt_q[0] == cpha);
    assign drive_edge = (ecnt_q[0] != cpha) && !(!cpha && ecnt_q == LAST);
    assign done       = shift_en && tick && (ecnt_q == LAST);
    assign rx_word    = cpha ? {rxs_q[DATA_W-2:0], miso} : rxs_q;
    assign sclk       = sclk_q;
    assign mosi       = mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            ecnt_q <= '0;
            txs_q  <= '0;
            rxs_q  <= '0;
        end else begin
            if (!shift_en) begin
                sclk_q <= cpol;
                ecnt_q <= '0;
            end else if (tick) begin
                sclk_q <= ~sclk_q;
                ecnt_q <= ecnt_q + 1'b1;
            end
            if (load) begin
                if (!cpha) begin
                    mosi_q <= load_data[DATA_W-1];
                    txs_q  <= load_data << 1;
                end else begin
                    txs_q  <= load_data;
                end
            end else if (shift_en && tick) begin
                if (samp_edge)
                    rxs_q <= {rxs_q[DATA_W-2:0], miso};
                if (drive_edge) begin
                    mosi_q <= txs_q[DATA_W-1];
                    txs_q  <= txs_q << 1;
                end
            end
        end
    end

    // Outside ticks the serial clock holds its level while a byte shifts
    assert_sclk_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !tick) |=> $stable(sclk_q));

    // After the sixteenth edge the clock rests at its idle level
    assert_sclk_rests_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sclk_q == $past(cpol)));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8,
    parameter int DIV_W  = 3,
    parameter int N_CS   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic [3*DLY_W-1:0]    dly_word,
    input  logic [DATA_W-1:0]     tx_data,
    input  logic                  tx_valid,
    output logic                  tx_ready,
    output logic [DATA_W-1:0]     rx_data,
    output logic                  rx_valid,
    input  logic                  rx_ready,
    output logic                  rx_lost,
    output logic                  tx_underflow,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso,
    output logic [N_CS-1:0]       cs_n
);
    localparam int DCW = DLY_W + 1;

    eng_state_t        state_q, state_d;
    logic              active, manual, cpol, cpha;
    logic [N_CS-1:0]   cs_field;
    logic [DIV_W-1:0]  div;
    logic [DLY_W-1:0]  dly_lead, dly_after, dly_gap;
    logic [DCW-1:0]    dcnt_q;
    logic              dzero, tick, done, accept, word_end;
    logic              rx_valid_q, uf_q;
    logic [DATA_W-1:0] rx_data_q, rx_word;

    assign active    = en && cfg_word[CFG_MASTER];
    assign manual    = cfg_word[CFG_MANCS];
    assign cpol      = cfg_word[CFG_CPOL];
    assign cpha      = cfg_word[CFG_CPHA];
    assign cs_field  = cfg_word[CFG_CS_LSB +: N_CS];
    assign div       = cfg_word[CFG_DIV_LSB +: DIV_W];
    assign dly_lead  = dly_word[0 +: DLY_W];
    assign dly_after = dly_word[DLY_W +: DLY_W];
    assign dly_gap   = dly_word[2*DLY_W +: DLY_W];
    assign dzero     = (dcnt_q == '0);
    assign accept    = tx_valid && tx_ready;

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .div   (div),
        .tick  (tick)
    );

    spi_bit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (tx_data),
        .cpol      (cpol),
        .cpha      (cpha),
        .shift_en  (state_q == ST_SHIFT),
        .tick      (tick),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .done      (done),
        .rx_word   (rx_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (accept)
                    state_d = (dly_lead != '0) ? ST_LEAD : ST_SHIFT;
            ST_LEAD:
                if (tick && dzero)
                    state_d = ST_SHIFT;
            ST_SHIFT:
                if (done)
                    state_d = (dly_after != '0) ? ST_TRAIL :
                              (dly_gap   != '0) ? ST_GAP   : ST_IDLE;
            ST_TRAIL:
                if (tick && dzero)
                    state_d = (dly_gap != '0) ? ST_GAP : ST_IDLE;
            ST_GAP:
                if (tick && dzero)
                    state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
        if (!active)
            state_d = ST_IDLE;
    end

    assign word_end = active && (state_d == ST_IDLE) &&
                      (state_q == ST_SHIFT || state_q == ST_TRAIL || state_q == ST_GAP);

    // State register and per-state delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                unique case (state_d)
                    ST_LEAD:  dcnt_q <= {dly_lead,  1'b0} - 1'b1;
                    ST_TRAIL: dcnt_q <= {dly_after, 1'b0} - 1'b1;
                    ST_GAP:   dcnt_q <= {dly_gap,   1'b0} - 1'b1;
                    default:  dcnt_q <= '0;
                endcase
            end else if (tick && !dzero) begin
                dcnt_q <= dcnt_q - 1'b1;
            end
        end
    end

    // Receive push and underflow pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
            uf_q       <= 1'b0;
        end else begin
            rx_valid_q <= done && active;
            if (done)
                rx_data_q <= rx_word;
            uf_q <= word_end && manual && (cs_field != '1) && !tx_valid;
        end
    end

    // Output decode
    always_comb begin
        tx_ready = active && (state_q == ST_IDLE);
        cs_n     = '1;
        if (active) begin
            if (manual)
                cs_n = cs_field;
            else if (state_q == ST_LEAD || state_q == ST_SHIFT || state_q == ST_TRAIL)
                cs_n = cs_field;
        end
    end

    assign rx_valid     = rx_valid_q;
    assign rx_data      = rx_data_q;
    assign rx_lost      = rx_valid_q && !rx_ready;
    assign tx_underflow = uf_q;

    assert_rx_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state_q == ST_IDLE));

    assert_abort_no_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rx_valid);

    assert_underflow_manual_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |-> $past(manual));

endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [14:0] cfg_word = '0;
    logic [23:0] dly_word = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic        rx_lost;
    logic        tx_underflow;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;
    logic        inv = 1'b0;

    always #4 clk = ~clk;

    assign miso = mosi ^ inv;

    spi_byte_master dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg_word), .dly_word(dly_word),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_lost(rx_lost),
        .tx_underflow(tx_underflow), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int checks = 0, errors = 0, cyc = 0;
    int edge_total = 0, edge_mark = 0, lost_cnt = 0, uf_cnt = 0, rx_cnt = 0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];
    logic [7:0] cap_sh = '0, e_tx, e_rx;
    int cap_n = 0;
    logic cur_cpol = 1'b0, cur_cpha = 1'b0, cap_en = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) cyc++;

    // Slave-side mosi capture at the sampling edge of the current mode
    always @(posedge sclk or negedge sclk or negedge cap_en) begin
        if (!cap_en) begin
            cap_n = 0;
        end else begin
            edge_total++;
            if (sclk == (cur_cpol ~^ cur_cpha)) begin
                cap_sh = {cap_sh[6:0], mosi};
                cap_n++;
                if (cap_n == 8) begin
                    cap_n = 0;
                    if (exp_tx.size() == 0)
                        chk(0, "R2 unexpected mosi byte", int'(cap_sh), -1);
                    else begin
                        e_tx = exp_tx.pop_front();
                        chk(cap_sh == e_tx, "R2 mosi byte at sampling edges", int'(cap_sh), int'(e_tx));
                    end
                end
            end
        end
    end

    // Receive monitor and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_lost) lost_cnt++;
            if (tx_underflow) uf_cnt++;
            if (rx_valid) begin
                rx_cnt++;
                if (exp_rx.size() == 0)
                    chk(0, "R3 unexpected rx_valid", int'(rx_data), -1);
                else begin
                    e_rx = exp_rx.pop_front();
                    chk(rx_data == e_rx, "R3 rx byte", int'(rx_data), int'(e_rx));
                end
                if (cap_en)
                    chk(edge_total - edge_mark == 16, "R3 sclk edges per byte",
                        edge_total - edge_mark, 16);
                edge_mark = edge_total;
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 0);
        finish_run();
    end

    function automatic logic [14:0] mk_cfg(input int dv, input bit pol, input bit pha,
                                           input logic [3:0] fld, input bit man, input bit mst);
        logic [14:0] c;
        c = '0;
        c[0] = mst; c[1] = pol; c[2] = pha;
        c[5:3] = 3'(dv); c[13:10] = fld; c[14] = man;
        return c;
    endfunction

    task automatic set_cfg(input int dv, input bit pol, input bit pha,
                           input logic [3:0] fld, input bit man);
        cap_en = 1'b0;
        @(negedge clk);
        cfg_word = mk_cfg(dv, pol, pha, fld, man, 1'b1);
        cur_cpol = pol;
        cur_cpha = pha;
        repeat (3) @(negedge clk);
        cap_en = 1'b1;
    endtask

    task automatic send_word(input logic [7:0] b);
        exp_tx.push_back(b);
        exp_rx.push_back(b ^ {8{inv}});
        @(negedge clk);
        tx_data = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_drained();
        while (exp_rx.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Observe one automatic-mode byte: lead, half-period, trail, gap (cycles)
    task automatic observe(output int t_lead, output int t_half,
                           output int t_trail, output int t_gap);
        int t_cs, t1, t2, t16, t_rise, edges, lim;
        logic prev;
        while (cs_n == 4'hF) @(negedge clk);
        t_cs = cyc; prev = sclk; edges = 0; t1 = 0; t2 = 0; t16 = 0;
        while (edges < 16) begin
            @(negedge clk);
            if (sclk != prev) begin
                edges++;
                prev = sclk;
                if (edges == 1) t1 = cyc;
                if (edges == 2) t2 = cyc;
                if (edges == 16) t16 = cyc;
            end
        end
        while (cs_n != 4'hF) @(negedge clk);
        t_rise = cyc;
        lim = 0;
        while (cs_n == 4'hF && lim < 400) begin
            @(negedge clk);
            lim++;
        end
        t_lead = t1 - t_cs;
        t_half = t2 - t1;
        t_trail = t_rise - t16;
        t_gap = cyc - t_rise;
    endtask

    initial begin
        int tl, th, tt, tg, rx0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset / disabled state
        chk(cs_n == 4'hF, "R4 cs_n after reset", int'(cs_n), 15);
        chk(sclk == 1'b0, "R4 sclk after reset", int'(sclk), 0);
        chk(tx_ready == 1'b0, "R4 tx_ready while disabled", int'(tx_ready), 0);
        chk(rx_valid == 1'b0, "R3 rx_valid after reset", int'(rx_valid), 0);

        // Mode 0, div 1, auto select of target 0, no delays
        en = 1'b1;
        set_cfg(1, 0, 0, 4'b1110, 0);
        chk(tx_ready == 1'b1, "R4 tx_ready when active", int'(tx_ready), 1);
        chk(cs_n == 4'hF, "R5 auto cs_n idle", int'(cs_n), 15);
        fork
            observe(tl, th, tt, tg);
            begin send_word(8'hA5); send_word(8'h3C); end
        join
        chk(th == 2, "R1 half-period div=1", th, 2);
        chk(tl == 2, "R7 lead with zero delay", tl, 2);
        chk(tt == 0, "R8 trail with zero delay", tt, 0);
        chk(tg == 1, "R9 gap with zero delay", tg, 1);
        wait_drained();
        chk(uf_cnt == 0, "R11 no underflow in auto mode", uf_cnt, 0);

        // Other three modes, inverted loopback, div 2
        inv = 1'b1;
        set_cfg(2, 0, 1, 4'b1101, 0);
        chk(sclk == 1'b0, "R2 idle level CPOL=0", int'(sclk), 0);
        send_word(8'h81); send_word(8'h7E); wait_drained();
        set_cfg(2, 1, 0, 4'b1011, 0);
        chk(sclk == 1'b1, "R2 idle level CPOL=1", int'(sclk), 1);
        send_word(8'hC3); send_word(8'h01); wait_drained();
        set_cfg(2, 1, 1, 4'b0111, 0);
        chk(sclk == 1'b1, "R2 idle level CPOL=1 CPHA=1", int'(sclk), 1);
        send_word(8'h5A); send_word(8'hFE); wait_drained();
        inv = 1'b0;

        // Delay timing: I=3, A=2, B=4, half=2
        set_cfg(1, 0, 0, 4'b1110, 0);
        dly_word = {8'd4, 8'd2, 8'd3};
        fork
            observe(tl, th, tt, tg);
            begin send_word(8'h96); send_word(8'h69); end
        join
        chk(tl == 14, "R7 lead delay I=3", tl, 14);
        chk(tt == 8, "R8 after delay A=2", tt, 8);
        chk(tg == 17, "R9 gap delay B=4", tg, 17);
        wait_drained();
        dly_word = '0;

        // Divider 3 and divider 0 (treated as 1)
        set_cfg(3, 0, 0, 4'b1110, 0);
        fork
            observe(tl, th, tt, tg);
            send_word(8'h42);
        join
        chk(th == 8, "R1 half-period div=3", th, 8);
        wait_drained();
        set_cfg(0, 0, 0, 4'b1110, 0);
        fork
            observe(tl, th, tt, tg);
            send_word(8'h24);
        join
        chk(th == 2, "R1 half-period div=0 as 1", th, 2);
        wait_drained();

        // Manual chip select and underflow
        set_cfg(1, 0, 0, 4'b1011, 1);
        chk(cs_n == 4'b1011, "R6 manual cs_n while idle", int'(cs_n), 11);
        send_word(8'hE7);
        wait_drained();
        chk(cs_n == 4'b1011, "R6 manual cs_n after byte", int'(cs_n), 11);
        chk(uf_cnt == 1, "R11 one underflow pulse", uf_cnt, 1);

        // Receive consumer not ready
        set_cfg(1, 0, 0, 4'b1110, 0);
        rx_ready = 1'b0;
        send_word(8'h3A);
        wait_drained();
        rx_ready = 1'b1;
        chk(lost_cnt == 1, "R10 rx_lost pulse", lost_cnt, 1);

        // Master bit cleared: nothing accepted
        rx0 = rx_cnt;
        cap_en = 1'b0;
        @(negedge clk);
        cfg_word = mk_cfg(1, 0, 0, 4'b1110, 0, 0);
        tx_valid = 1'b1;
        tx_data = 8'hAA;
        repeat (60) @(negedge clk);
        chk(tx_ready == 1'b0, "R4 tx_ready with master off", int'(tx_ready), 0);
        chk(cs_n == 4'hF, "R4 cs_n with master off", int'(cs_n), 15);
        chk(rx_cnt == rx0, "R4 no byte with master off", rx_cnt, rx0);
        tx_valid = 1'b0;

        // Abort mid-byte
        cfg_word = mk_cfg(3, 1, 0, 4'b1110, 0, 1);
        cur_cpol = 1'b1;
        repeat (3) @(negedge clk);
        tx_valid = 1'b1;
        tx_data = 8'h55;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (45) @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs_n == 4'hF, "R12 cs_n after abort", int'(cs_n), 15);
        chk(sclk == 1'b1, "R12 sclk idle after abort", int'(sclk), 1);
        repeat (300) @(negedge clk);
        chk(rx_cnt == rx0, "R12 no rx after abort", rx_cnt, rx0);
        en = 1'b1;
        set_cfg(1, 1, 0, 4'b1110, 0);
        send_word(8'h0F);
        wait_drained();
        chk(rx_cnt == rx0 + 1, "R12 engine resumes after abort", rx_cnt, rx0 + 1);

        finish_run();
    end
endmodule